// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block is the control core of a battery-free nonvolatile SRAM. It holds a byte-wide volatile array together with a shadow nonvolatile copy of the same size. It moves the whole array in a single operation: a STORE copies the array into the shadow, and a RECALL copies the shadow back into the array. A RECALL runs once after every reset. No SRAM access is allowed until it has finished.

Normal access uses active-low chip-enable, output-enable and write-enable strobes. A write commits on the cycle its strobes end. Three sources can start a STORE:
- an external low pulled onto the shared busy line,
- a software request,
- a supply-low indicator, when automatic save is enabled.

While a STORE runs, the block pulls the busy line low. It then drives the line high for a short window and releases it to the pull-up. All accesses are inhibited during a transfer. A store started by the supply-low indicator parks the block until the next reset.

A saturating counter tracks completed STOREs and raises a wear flag at a limit. The array depth is 2^ADDR_W bytes. A full-size array uses ADDR_W = 15 (32,768 bytes); the default is kept smaller.

Top module: `nvs_ctrl`

## Requirements
- R1: After reset release the block performs a RECALL lasting RECALL_CYC cycles. SRAM access stays blocked for those cycles, and afterwards the array holds the shadow contents.
- R2: rdata_oe_o is 1 and rdata_o shows the byte at addr_i only when the block is idle, ce_ni=0, oe_ni=0, we_ni=1 and busy_i=1. Otherwise rdata_oe_o=0 and rdata_o=0.
- R3: A write is active while idle with ce_ni=0, we_ni=0 and busy_i=1. It commits the address and data of its last active cycle on the clock edge where ce_ni or we_ni is seen high.
- R4: rdata_oe_o is never 1 while we_ni is 0, even with oe_ni held low.
- R5: No read is enabled and no write commits during a STORE, a RECALL or the busy-high window.
- R6: A STORE starts on a falling edge of busy_i, on sw_store_i=1, or on pwr_fail_i=1 while automatic save is enabled. Each of these is accepted only when idle.
- R7: busy_pd_o is 1 for exactly STORE_CYC cycles. It is followed by busy_pu_o=1 for exactly HIGH_CYC cycles, after which both are 0. The two are never 1 together.
- R8: A STORE copies the whole array into the shadow, so a later RECALL returns the data present when the STORE began.
- R9: A store request arriving while a transfer is busy is ignored and does not cause a second STORE.
- R10: auto_en_o is 1 after reset and is cleared by auto_dis_i=1 until the next reset. While it is 0, pwr_fail_i starts nothing.
- R11: After a STORE started by pwr_fail_i completes, no request is accepted and no access is enabled until reset.
- R12: store_cnt_o resets to 0 and increments by one per completed STORE. It saturates at all ones. wear_o is 1 when store_cnt_o >= WEAR_LIMIT.
- R13: done_o is a one-cycle pulse in the last cycle of every STORE and RECALL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, zero when not driving |
| rdata_oe_o | output | 1 | Read data bus drive enable |
| busy_i | input | 1 | Sensed level of the shared busy line |
| busy_pd_o | output | 1 | Pull the busy line low (STORE running) |
| busy_pu_o | output | 1 | Drive the busy line high (post-STORE window) |
| sw_store_i | input | 1 | Software STORE request |
| pwr_fail_i | input | 1 | Supply-low indicator |
| auto_dis_i | input | 1 | Software command disabling automatic save |
| auto_en_o | output | 1 | Automatic save enabled |
| done_o | output | 1 | Transfer completion pulse |
| store_cnt_o | output | CNT_W | Completed STORE count, saturating |
| wear_o | output | 1 | STORE count reached the wear limit |

## Verification
The bench targets a write whose data changes mid-cycle, where a design that latched the first beat instead of the last would commit stale data. It pokes a software request in the middle of a STORE and counts the resulting stores; a design that queued the request would run two. It checks the exact lengths of the pull-low and drive-high phases, and a design with an off-by-one in either counter would miss the expected count. It drives a supply-low store together with a software request and then tries further requests; a design without the parked state would start another STORE. It pushes the counter past its all-ones value; a non-saturating design would wrap to zero and drop the wear flag.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_RECALL,
    ST_IDLE,
    ST_STORE,
    ST_DRIVE,
    ST_HALT
  } nvs_state_e;
endpackage

// File: rtl/nvs_seq.sv
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int STORE_CYC  = 16,
  parameter int RECALL_CYC = 16,
  parameter int HIGH_CYC   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_req_i,
  input  logic       sw_req_i,
  input  logic       pf_req_i,
  output nvs_state_e state_o,
  output logic       store_done_o,
  output logic       recall_done_o
);
  localparam int MAX_A = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int MAX_C = (MAX_A > HIGH_CYC) ? MAX_A : HIGH_CYC;
  localparam int CW    = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  nvs_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic          auto_q;

  assign state_o       = st_q;
  assign store_done_o  = (st_q == ST_STORE)  && (cnt_q == '0);
  assign recall_done_o = (st_q == ST_RECALL) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RECALL;
      cnt_q  <= CW'(RECALL_CYC - 1);
      auto_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RECALL: begin
          if (cnt_q == '0) st_q <= ST_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_IDLE: begin
          if (pf_req_i || ext_req_i || sw_req_i) begin
            st_q   <= ST_STORE;
            cnt_q  <= CW'(STORE_CYC - 1);
            auto_q <= pf_req_i;
          end
        end
        ST_STORE: begin
          if (cnt_q == '0) begin
            st_q  <= ST_DRIVE;
            cnt_q <= CW'(HIGH_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_DRIVE: begin
          if (cnt_q == '0) st_q <= auto_q ? ST_HALT : ST_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_act_i,
  input  logic              wr_ok_i,
  input  logic              wr_stop_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              store_i,
  input  logic              recall_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] nv  [DEPTH];
  logic              wr_act_q;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q;
  logic              commit;

  // commit only when the strobes end, not when a transfer cuts the cycle
  assign commit  = wr_act_q && wr_ok_i && wr_stop_i;
  assign rdata_o = rd_en_i ? mem[addr_i] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q <= 1'b0;
      wa_q     <= '0;
      wd_q     <= '0;
    end else begin
      wr_act_q <= wr_act_i;
      if (wr_act_i) begin
        wa_q <= addr_i;
        wd_q <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (recall_i) mem <= nv;
    else if (commit) mem[wa_q] <= wd_q;
    if (store_i) nv <= mem;
  end
endmodule

// File: rtl/nvs_wear.sv
module nvs_wear #(
  parameter int CNT_W      = 20,
  parameter int WEAR_LIMIT = 1_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wear_o
);
  localparam logic [31:0] LIMIT = 32'(WEAR_LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wear_o = 32'(cnt_q) >= LIMIT;
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int STORE_CYC  = 16,
  parameter int RECALL_CYC = 16,
  parameter int HIGH_CYC   = 4,
  parameter int CNT_W      = 20,
  parameter int WEAR_LIMIT = 1_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  input  logic              busy_i,
  output logic              busy_pd_o,
  output logic              busy_pu_o,
  input  logic              sw_store_i,
  input  logic              pwr_fail_i,
  input  logic              auto_dis_i,
  output logic              auto_en_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  store_cnt_o,
  output logic              wear_o
);
  nvs_state_e state;
  logic       store_done, recall_done;
  logic       busy_q, auto_en_q;
  logic       idle, ext_req, pf_req, rd_en, wr_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b1;
      auto_en_q <= 1'b1;
    end else begin
      busy_q <= busy_i;
      if (auto_dis_i) auto_en_q <= 1'b0;
    end
  end

  assign idle    = (state == ST_IDLE);
  assign ext_req = busy_q && !busy_i;
  assign pf_req  = pwr_fail_i && auto_en_q;
  assign rd_en   = idle && !ce_ni && !oe_ni && we_ni && busy_i;
  assign wr_act  = idle && !ce_ni && !we_ni && busy_i;

  nvs_seq #(
    .STORE_CYC (STORE_CYC),
    .RECALL_CYC(RECALL_CYC),
    .HIGH_CYC  (HIGH_CYC)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ext_req_i    (ext_req),
    .sw_req_i     (sw_store_i),
    .pf_req_i     (pf_req),
    .state_o      (state),
    .store_done_o (store_done),
    .recall_done_o(recall_done)
  );

  nvs_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en),
    .wr_act_i (wr_act),
    .wr_ok_i  (idle && busy_i),
    .wr_stop_i(ce_ni || we_ni),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .store_i  (store_done),
    .recall_i (recall_done),
    .rdata_o  (rdata_o)
  );

  nvs_wear #(
    .CNT_W     (CNT_W),
    .WEAR_LIMIT(WEAR_LIMIT)
  ) u_wear (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (store_done),
    .cnt_o (store_cnt_o),
    .wear_o(wear_o)
  );

  assign rdata_oe_o = rd_en;
  assign busy_pd_o  = (state == ST_STORE);
  assign busy_pu_o  = (state == ST_DRIVE);
  assign auto_en_o  = auto_en_q;
  assign done_o     = store_done || recall_done;
endmodule

// File: rtl/nvs_ctrl_chk.sv
module nvs_ctrl_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_ni,
  input logic             oe_ni,
  input logic             we_ni,
  input logic             rdata_oe_o,
  input logic             busy_i,
  input logic             busy_pd_o,
  input logic             busy_pu_o,
  input logic             auto_en_o,
  input logic             done_o,
  input logic [CNT_W-1:0] store_cnt_o
);
  a_r2_read_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> (!ce_ni && !oe_ni && busy_i));

  a_r4_no_drive_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |-> !rdata_oe_o);

  a_r5_no_access_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_pd_o || busy_pu_o) |-> !rdata_oe_o);

  a_r7_pd_pu_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_pd_o && busy_pu_o));

  a_r7_high_after_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_pd_o) |-> busy_pu_o);

  a_r10_auto_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_o |=> !auto_en_o);

  a_r12_cnt_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&store_cnt_o) |=> (&store_cnt_o));

  a_r12_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_cnt_o != $past(store_cnt_o)) |-> (store_cnt_o == CNT_W'($past(store_cnt_o) + 1'b1)));

  a_r13_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind nvs_ctrl nvs_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/nvs_ctrl_test.sv
`timescale 1ns/1ps
module nvs_ctrl_test;
  localparam int AW = 6;
  localparam int SC = 6;
  localparam int RC = 4;
  localparam int HC = 2;
  localparam int CW = 3;
  localparam int WL = 5;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata_o;
  logic          rdata_oe_o;
  logic          busy_i, busy_pd_o, busy_pu_o;
  logic          ext_low = 1'b0;
  logic          sw_store = 1'b0, pwr_fail = 1'b0, auto_dis = 1'b0;
  logic          auto_en_o, done_o, wear_o;
  logic [CW-1:0] store_cnt_o;

  always #2.5 clk = ~clk;

  // wired busy line: block pull-down or external pull-down, else pull-up
  assign busy_i = (ext_low || busy_pd_o) ? 1'b0 : 1'b1;

  nvs_ctrl #(
    .ADDR_W(AW), .DATA_W(8), .STORE_CYC(SC), .RECALL_CYC(RC),
    .HIGH_CYC(HC), .CNT_W(CW), .WEAR_LIMIT(WL)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o),
    .busy_i(busy_i), .busy_pd_o(busy_pd_o), .busy_pu_o(busy_pu_o),
    .sw_store_i(sw_store), .pwr_fail_i(pwr_fail), .auto_dis_i(auto_dis),
    .auto_en_o(auto_en_o), .done_o(done_o), .store_cnt_o(store_cnt_o), .wear_o(wear_o)
  );

  int n_chk = 0, n_fail = 0, n_store = 0;
  bit finished = 0;
  logic [7:0] model_mem [64];
  logic [7:0] model_nv  [64];

  typedef struct {logic oe; logic [7:0] data; string req;} exp_t;
  exp_t sb_q[$];
  exp_t mon_e;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compares read bus one ns after each edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      mon_e = sb_q.pop_front();
      chk(mon_e.req, {23'd0, rdata_oe_o, rdata_o}, {23'd0, mon_e.oe, mon_e.data});
    end
  end

  task automatic rd(int a, bit c, bit o, bit on, string req);
    @(negedge clk);
    ce_ni = c; oe_ni = o; we_ni = 1'b1; addr = AW'(a);
    sb_q.push_back('{on, on ? model_mem[a] : 8'h00, req});
    @(negedge clk);
    ce_ni = 1'b1; oe_ni = 1'b1;
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    ce_ni = 1'b0; we_ni = 1'b0; oe_ni = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we_ni = 1'b1;
    @(negedge clk);
    ce_ni = 1'b1;
    model_mem[a] = d;
  endtask

  task automatic chk_cnt(string req);
    int e;
    e = (n_store > 7) ? 7 : n_store;
    chk(req, 32'(store_cnt_o), 32'(e));
    chk(req, 32'(wear_o), 32'(e >= WL));
  endtask

  // src: 0 software, 1 busy pin, 2 power fail, 3 power fail with software
  task automatic do_store(int src, bit poke);
    int pd = 0, pu = 0, dn = 0;
    @(negedge clk);
    ce_ni = 1'b0; oe_ni = 1'b0; we_ni = 1'b1; addr = '0;
    case (src)
      0: sw_store = 1'b1;
      1: ext_low = 1'b1;
      2: pwr_fail = 1'b1;
      default: begin pwr_fail = 1'b1; sw_store = 1'b1; end
    endcase
    @(negedge clk);
    sw_store = 1'b0; ext_low = 1'b0; pwr_fail = 1'b0;
    while (busy_pd_o && pd < 100) begin
      pd++;
      if (done_o) dn++;
      if (rdata_oe_o) chk("R5 read during store", 1, 0);
      sw_store = poke && (pd == 2);
      @(negedge clk);
    end
    sw_store = 1'b0;
    while (busy_pu_o && pu < 100) begin
      pu++;
      @(negedge clk);
    end
    ce_ni = 1'b1; oe_ni = 1'b1;
    chk("R7 pull-low cycles", 32'(pd), 32'(SC));
    chk("R7 drive-high cycles", 32'(pu), 32'(HC));
    chk("R13 store done pulses", 32'(dn), 32'd1);
    chk("R7 line released", {busy_pd_o, busy_pu_o}, 32'd0);
    for (int i = 0; i < 64; i++) model_nv[i] = model_mem[i];
    n_store++;
  endtask

  task automatic do_reset();
    int blk = 0, dn = 0;
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R12 count at reset", 32'(store_cnt_o), 0);
    chk("R10 auto enable at reset", 32'(auto_en_o), 1);
    chk("R7 busy outputs at reset", {busy_pd_o, busy_pu_o}, 0);
    ce_ni = 1'b0; oe_ni = 1'b0; we_ni = 1'b1; addr = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    while (!rdata_oe_o && blk < 50) begin
      if (done_o) dn++;
      blk++;
      @(negedge clk);
    end
    ce_ni = 1'b1; oe_ni = 1'b1;
    chk("R1 recall blocking cycles", 32'(blk), 32'(RC));
    chk("R13 recall done pulses", 32'(dn), 1);
    for (int i = 0; i < 64; i++) model_mem[i] = model_nv[i];
    n_store = 0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin model_mem[i] = 8'h00; model_nv[i] = 8'h00; end
    repeat (2) @(negedge clk);
    do_reset();

    // R2 R3 basic access
    wr(3, 8'hA5);
    wr(10, 8'h3C);
    rd(3, 0, 0, 1, "R2 read addr 3");
    rd(10, 0, 0, 1, "R3 read addr 10");
    rd(3, 0, 1, 0, "R2 oe high blocks read");
    rd(3, 1, 0, 0, "R2 ce high blocks read");

    // R3 last active beat commits, ce-controlled end
    @(negedge clk);
    ce_ni = 1'b0; we_ni = 1'b0; addr = AW'(5); wdata = 8'h11;
    @(negedge clk);
    wdata = 8'h22;
    @(negedge clk);
    ce_ni = 1'b1;
    @(negedge clk);
    we_ni = 1'b1;
    model_mem[5] = 8'h22;
    rd(5, 0, 0, 1, "R3 last beat committed");

    // R4 oe low during write
    @(negedge clk);
    ce_ni = 1'b0; oe_ni = 1'b0; we_ni = 1'b0; addr = AW'(7); wdata = 8'h5A;
    @(negedge clk);
    chk("R4 no drive while writing", 32'(rdata_oe_o), 0);
    ce_ni = 1'b1; we_ni = 1'b1;
    @(negedge clk);
    oe_ni = 1'b1;
    model_mem[7] = 8'h5A;
    rd(7, 0, 0, 1, "R4 write with oe low");

    // R6 R9 software store with a poke while busy
    do_store(0, 1);
    chk_cnt("R9 poke ignored, one store");

    // R8 overwrite, then recall restores the stored image
    wr(3, 8'hFF);
    rd(3, 0, 0, 1, "R8 overwrite visible");
    do_reset();
    rd(3, 0, 0, 1, "R8 recall restores stored byte");
    rd(5, 0, 0, 1, "R8 recall restores addr 5");

    // R6 store from the busy line
    do_store(1, 0);
    chk_cnt("R6 pin store counted");

    // R10 disable automatic save
    @(negedge clk);
    auto_dis = 1'b1;
    @(negedge clk);
    auto_dis = 1'b0;
    chk("R10 auto cleared", 32'(auto_en_o), 0);
    pwr_fail = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R10 power fail ignored", 32'(busy_pd_o), 0);
    end
    pwr_fail = 1'b0;
    chk_cnt("R10 no store counted");

    // R12 wear flag and saturation
    for (int k = 0; k < 7; k++) begin
      do_store(0, 0);
      chk_cnt("R12 count and wear");
    end

    // R11 power-fail store with a concurrent software request, then park
    do_reset();
    wr(20, 8'h77);
    do_store(3, 0);
    chk_cnt("R6 power fail store counted");
    @(negedge clk);
    sw_store = 1'b1;
    @(negedge clk);
    sw_store = 1'b0; ext_low = 1'b1;
    @(negedge clk);
    ext_low = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R11 no store after power fail", {busy_pd_o, busy_pu_o}, 0);
    end
    rd(20, 0, 0, 0, "R11 access blocked after power fail");
    chk_cnt("R11 count unchanged");
    do_reset();
    rd(20, 0, 0, 1, "R8 power fail image recalled");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule